// File: doc/BRIEF.md
# Typed-Operand Compare Flag Unit

This unit produces the four condition flags (zero, negative, carry, overflow) for the word, halfword and byte compare instructions of a 32-bit processor. Each of the two operands comes with a 3-bit datatype tag. The tag can override the size that the compare opcode would otherwise imply. Each raw 32-bit operand is widened to 32 bits as its tag directs: signed types are sign-extended and unsigned types are zero-extended. The zero and carry flags come from the full widened values. The negative flag is a signed less-than test whose width is set by the second operand's tag and not by the opcode.

The decode stage presents the opcode size, both operands and both tags, and pulses `valid_i` for one cycle. The flags are registered on that edge and keep their value until the next strobe. A tag value outside the six defined encodings is replaced by the opcode's default type. The same strobe then raises a one-cycle error indication.

Top module: `cmp_flag_unit`

## Requirements
- R1: Tag encodings are 0 signed word, 1 unsigned word, 2 signed halfword, 3 unsigned halfword, 4 unsigned byte and 5 signed byte. Halfword and byte operands use their low 16 or 8 bits. Signed types are sign-extended to 32 bits and unsigned types are zero-extended. Word types are used unchanged.
- R2: The zero flag is 1 exactly when the two extended operands are equal in all 32 bits.
- R3: The carry flag is 1 exactly when extended operand 2 is less than extended operand 1, compared as unsigned 32-bit values.
- R4: The negative flag is 1 exactly when operand 2 is less than operand 1 as two's complement numbers. The test uses the low 32, 16 or 8 bits of the extended values: 32 when operand 2's effective tag is a word type, 16 for a halfword type, 8 for a byte type.
- R5: The overflow flag reads 0 after every compare.
- R6: The opcode size encoding is 0 byte, 1 halfword, 2 word, and 3 is treated as word. An operand with a reserved tag (6 or 7) takes the opcode's default type instead: unsigned byte for byte, signed halfword for halfword, and signed word for word.
- R7: `tag_err_o` is 1 in the cycle that follows a strobe on which either tag was reserved. It is 0 in every other cycle.
- R8: The flags change only in the cycle after a cycle with `valid_i` high. In all other cycles they hold their value, whatever the other inputs do.
- R9: A synchronous active-high reset clears all four flags and `tag_err_o`.
- R10: When both tags are defined encodings, the opcode size has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Compare strobe, one cycle per compare |
| op_size_i | input | 2 | Opcode default size (0 byte, 1 half, 2/3 word) |
| opnd1_i | input | 32 | Raw operand 1 |
| tag1_i | input | 3 | Datatype tag of operand 1 |
| opnd2_i | input | 32 | Raw operand 2 |
| tag2_i | input | 3 | Datatype tag of operand 2 |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |
| tag_err_o | output | 1 | Reserved-tag indication, one cycle |

## Verification
The unit has no hidden state apart from its flag and error registers, so any fault shows at the ports in the cycle right after the strobe that exposes it. A wrong extension rule changes Z or C only for operands whose discarded upper bits matter. For that reason the stimulus mixes values with set sign bits, values that agree only in their low bits, and operands of equal value. An N width taken from the wrong operand or from the opcode shows only when the two tags differ in width. A broken hold path shows as a flag change on a cycle with the strobe low.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
  localparam int DW = 32;
  localparam int HW = DW / 2;
  localparam int BW = DW / 4;
  localparam int TAG_W = 3;
  localparam int SZ_W = 2;

  typedef enum logic [TAG_W-1:0] {
    T_SWORD = 3'd0,
    T_UWORD = 3'd1,
    T_SHALF = 3'd2,
    T_UHALF = 3'd3,
    T_UBYTE = 3'd4,
    T_SBYTE = 3'd5,
    T_RSV6  = 3'd6,
    T_RSV7  = 3'd7
  } optag_e;

  typedef enum logic [SZ_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } opsize_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  function automatic logic tag_is_rsv(optag_e t);
    return (t == T_RSV6) || (t == T_RSV7);
  endfunction

  function automatic optag_e size_default(opsize_e s);
    case (s)
      SZ_BYTE: return T_UBYTE;
      SZ_HALF: return T_SHALF;
      default: return T_SWORD;
    endcase
  endfunction

  function automatic logic [DW-1:0] extend_op(logic [DW-1:0] v, optag_e t);
    case (t)
      T_SHALF: return {{(DW-HW){v[HW-1]}}, v[HW-1:0]};
      T_UHALF: return {{(DW-HW){1'b0}}, v[HW-1:0]};
      T_SBYTE: return {{(DW-BW){v[BW-1]}}, v[BW-1:0]};
      T_UBYTE: return {{(DW-BW){1'b0}}, v[BW-1:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic signed_less(logic [DW-1:0] b, logic [DW-1:0] a, optag_e t);
    case (t)
      T_SHALF, T_UHALF: return $signed(b[HW-1:0]) < $signed(a[HW-1:0]);
      T_SBYTE, T_UBYTE: return $signed(b[BW-1:0]) < $signed(a[BW-1:0]);
      default:          return $signed(b) < $signed(a);
    endcase
  endfunction
endpackage

// File: rtl/cmpf_tag_resolve.sv
module cmpf_tag_resolve
  import cmpf_pkg::*;
(
  input  logic [TAG_W-1:0] tag_i,
  input  logic [SZ_W-1:0]  size_i,
  output optag_e           eff_tag_o,
  output logic             rsv_o
);
  optag_e  raw_tag;
  opsize_e size_e;

  always_comb begin
    raw_tag   = optag_e'(tag_i);
    size_e    = opsize_e'(size_i);
    rsv_o     = tag_is_rsv(raw_tag);
    eff_tag_o = rsv_o ? size_default(size_e) : raw_tag;
  end

  always_comb begin
    // R6
    eff_defined_chk: assert (!tag_is_rsv(eff_tag_o))
      else $error("effective tag still reserved");
  end
endmodule

// File: rtl/cmpf_extend.sv
module cmpf_extend
  import cmpf_pkg::*;
(
  input  logic [DW-1:0] val_i,
  input  optag_e        tag_i,
  output logic [DW-1:0] ext_o
);
  always_comb ext_o = extend_op(val_i, tag_i);

  always_comb begin
    // R1
    zext_upper_chk: assert (!((tag_i == T_UBYTE && ext_o[DW-1:BW] != '0) ||
                              (tag_i == T_UHALF && ext_o[DW-1:HW] != '0)))
      else $error("unsigned operand has upper bits set");
    // R1
    low_keep_chk: assert (ext_o[BW-1:0] == val_i[BW-1:0])
      else $error("low byte altered by extension");
  end
endmodule

// File: rtl/cmpf_flag_calc.sv
module cmpf_flag_calc
  import cmpf_pkg::*;
(
  input  logic [DW-1:0] ext1_i,
  input  logic [DW-1:0] ext2_i,
  input  optag_e        tag2_i,
  output flags_t        flags_o
);
  logic eq_full;
  logic lt_unsigned;
  logic lt_signed_w;

  always_comb begin
    eq_full     = (ext2_i == ext1_i);
    lt_unsigned = (ext2_i < ext1_i);
    lt_signed_w = signed_less(ext2_i, ext1_i, tag2_i);
    flags_o.z   = eq_full;
    flags_o.n   = lt_signed_w;
    flags_o.c   = lt_unsigned;
    flags_o.v   = 1'b0;
  end

  always_comb begin
    // R2
    z_c_excl_chk: assert (!(eq_full && lt_unsigned))
      else $error("zero and carry both set");
    // R4
    z_n_excl_chk: assert (!(eq_full && lt_signed_w))
      else $error("zero and negative both set");
  end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmpf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [SZ_W-1:0]  op_size_i,
  input  logic [DW-1:0]    opnd1_i,
  input  logic [TAG_W-1:0] tag1_i,
  input  logic [DW-1:0]    opnd2_i,
  input  logic [TAG_W-1:0] tag2_i,
  output logic             flag_z_o,
  output logic             flag_n_o,
  output logic             flag_c_o,
  output logic             flag_v_o,
  output logic             tag_err_o
);
  localparam int NOPND = 2;

  logic [NOPND-1:0][DW-1:0]    raw_val;
  logic [NOPND-1:0][TAG_W-1:0] raw_tag;
  optag_e                      eff_tag [NOPND];
  logic [NOPND-1:0]            tag_rsv;
  logic [NOPND-1:0][DW-1:0]    ext_val;
  flags_t                      next_flags;
  flags_t                      flags_q;
  logic                        err_q;
  logic                        any_rsv;

  assign raw_val = {opnd2_i, opnd1_i};
  assign raw_tag = {tag2_i, tag1_i};

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    cmpf_tag_resolve u_res (
      .tag_i    (raw_tag[g]),
      .size_i   (op_size_i),
      .eff_tag_o(eff_tag[g]),
      .rsv_o    (tag_rsv[g])
    );
    cmpf_extend u_ext (
      .val_i(raw_val[g]),
      .tag_i(eff_tag[g]),
      .ext_o(ext_val[g])
    );
  end

  cmpf_flag_calc u_calc (
    .ext1_i (ext_val[0]),
    .ext2_i (ext_val[1]),
    .tag2_i (eff_tag[1]),
    .flags_o(next_flags)
  );

  assign any_rsv = |tag_rsv;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= valid_i && any_rsv;
      if (valid_i) flags_q <= next_flags;
    end
  end

  assign flag_z_o  = flags_q.z;
  assign flag_n_o  = flags_q.n;
  assign flag_c_o  = flags_q.c;
  assign flag_v_o  = flags_q.v;
  assign tag_err_o = err_q;

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags_q == '0 && !tag_err_o));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(flags_q));

  // R7
  err_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (tag1_i[2:1] == 2'b11 || tag2_i[2:1] == 2'b11)) |=> tag_err_o);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !tag_err_o);
endmodule

// File: tb/cmp_flag_unit_tb_top.sv
module cmp_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [1:0]  op_size_i;
  logic [31:0] opnd1_i, opnd2_i;
  logic [2:0]  tag1_i, tag2_i;
  logic        flag_z_o, flag_n_o, flag_c_o, flag_v_o, tag_err_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  cmp_flag_unit dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_size_i(op_size_i),
    .opnd1_i(opnd1_i), .tag1_i(tag1_i), .opnd2_i(opnd2_i), .tag2_i(tag2_i),
    .flag_z_o(flag_z_o), .flag_n_o(flag_n_o), .flag_c_o(flag_c_o),
    .flag_v_o(flag_v_o), .tag_err_o(tag_err_o)
  );

  // bench model, written from the requirements
  function automatic logic [2:0] eff(logic [2:0] t, logic [1:0] s);
    if (t < 3'd6) return t;
    if (s == 2'd0) return 3'd4;
    if (s == 2'd1) return 3'd2;
    return 3'd0;
  endfunction

  function automatic logic [31:0] widen(logic [31:0] v, logic [2:0] t);
    logic [31:0] r;
    r = v;
    if (t == 3'd2 || t == 3'd3) r = {16'h0, v[15:0]};
    if (t == 3'd4 || t == 3'd5) r = {24'h0, v[7:0]};
    if (t == 3'd2 && v[15]) r = r | 32'hFFFF_0000;
    if (t == 3'd5 && v[7])  r = r | 32'hFFFF_FF00;
    return r;
  endfunction

  function automatic logic model_n(logic [31:0] b, logic [31:0] a, logic [2:0] t);
    int sb, sa;
    if (t == 3'd2 || t == 3'd3) begin
      sb = int'(b[15:0]) - (b[15] ? 65536 : 0);
      sa = int'(a[15:0]) - (a[15] ? 65536 : 0);
      return sb < sa;
    end
    if (t == 3'd4 || t == 3'd5) begin
      sb = int'(b[7:0]) - (b[7] ? 256 : 0);
      sa = int'(a[7:0]) - (a[7] ? 256 : 0);
      return sb < sa;
    end
    return (b ^ 32'h8000_0000) < (a ^ 32'h8000_0000);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] s, logic [31:0] a, logic [2:0] ta,
                       logic [31:0] b, logic [2:0] tb);
    @(negedge clk);
    op_size_i = s; opnd1_i = a; tag1_i = ta; opnd2_i = b; tag2_i = tb;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run_model(logic [1:0] s, logic [31:0] a, logic [2:0] ta,
                           logic [31:0] b, logic [2:0] tb);
    logic [31:0] ea, eb;
    logic [2:0]  etb;
    ea  = widen(a, eff(ta, s));
    etb = eff(tb, s);
    eb  = widen(b, etb);
    apply(s, a, ta, b, tb);
    check("R2 zero", flag_z_o, eb == ea);
    check("R3 carry", flag_c_o, eb < ea);
    check("R4 negative", flag_n_o, model_n(eb, ea, etb));
    check("R5 overflow", flag_v_o, 1'b0);
    check("R7 error", tag_err_o, (ta >= 3'd6) || (tb >= 3'd6));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic z0, n0, c0;
    void'($urandom(32'd1234));
    rst = 1'b1; valid_i = 1'b0; op_size_i = 2'd2;
    opnd1_i = 32'hFFFF_FFFF; opnd2_i = 32'h0; tag1_i = 3'd0; tag2_i = 3'd0;
    // drive a strobe during reset: must not leave flags set (R9)
    @(negedge clk); valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    @(negedge clk);
    check("R9 reset z", flag_z_o, 1'b0);
    check("R9 reset n", flag_n_o, 1'b0);
    check("R9 reset c", flag_c_o, 1'b0);
    check("R9 reset v", flag_v_o, 1'b0);
    check("R9 reset err", tag_err_o, 1'b0);
    rst = 1'b0;

    // R1 R4: halfword opcode, word tags -> full 32-bit compare
    apply(2'd1, 32'h0001_0000, 3'd0, 32'h0000_0005, 3'd0);
    check("R4 word N", flag_n_o, 1'b1);
    check("R3 word C", flag_c_o, 1'b1);
    // R4: op2 as signed halfword -> N from low 16 bits (5 < 0 false)
    apply(2'd1, 32'h0001_0000, 3'd0, 32'h0000_0005, 3'd2);
    check("R4 half N", flag_n_o, 1'b0);
    check("R3 half C", flag_c_o, 1'b1);
    // R1: unsigned byte 0x80 vs signed byte 0x80
    apply(2'd0, 32'h0000_0080, 3'd4, 32'h1234_5680, 3'd5);
    check("R1 byte Z", flag_z_o, 1'b0);
    check("R1 byte C", flag_c_o, 1'b0);
    check("R4 byte N", flag_n_o, 1'b0);
    // R1: unsigned halfword zero-extends, upper bits ignored
    apply(2'd2, 32'hAAAA_8001, 3'd3, 32'h5555_8001, 3'd3);
    check("R1 uhalf Z", flag_z_o, 1'b1);
    // R6 R7: reserved tags take byte default (unsigned byte)
    apply(2'd0, 32'h0000_01FF, 3'd6, 32'h0000_00FF, 3'd7);
    check("R6 rsv Z", flag_z_o, 1'b1);
    check("R6 rsv N", flag_n_o, 1'b0);
    check("R7 err set", tag_err_o, 1'b1);
    @(negedge clk);
    check("R7 err one cycle", tag_err_o, 1'b0);
    // R6: halfword default is signed halfword, word default signed word
    apply(2'd1, 32'h0000_0001, 3'd0, 32'h0000_FFFF, 3'd7);
    check("R6 half default N", flag_n_o, 1'b1);
    check("R6 half default C", flag_c_o, 1'b0);
    apply(2'd3, 32'h0000_0001, 3'd0, 32'h8000_0000, 3'd6);
    check("R6 word default N", flag_n_o, 1'b1);

    // R8: hold while strobe low, inputs change
    z0 = flag_z_o; n0 = flag_n_o; c0 = flag_c_o;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      opnd1_i = $urandom; opnd2_i = $urandom;
      tag1_i = 3'($urandom); tag2_i = 3'($urandom); op_size_i = 2'($urandom);
    end
    @(negedge clk);
    check("R8 hold z", flag_z_o, z0);
    check("R8 hold n", flag_n_o, n0);
    check("R8 hold c", flag_c_o, c0);

    // R10: size irrelevant with defined tags
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      logic [2:0]  ta, tb;
      a = $urandom; b = (i % 3 == 0) ? a : $urandom;
      ta = 3'($urandom % 6); tb = 3'($urandom % 6);
      apply(2'd0, a, ta, b, tb);
      z0 = flag_z_o; n0 = flag_n_o; c0 = flag_c_o;
      apply(2'(1 + ($urandom % 3)), a, ta, b, tb);
      check("R10 size z", flag_z_o, z0);
      check("R10 size n", flag_n_o, n0);
      check("R10 size c", flag_c_o, c0);
    end

    // random mix against model (R1..R7)
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      case ($urandom % 4)
        0: b = a;
        1: b = {$urandom_range(0, 65535) & 32'hFFFF, a[15:0]};
        2: b = {a[31:8], 8'($urandom)};
        default: b = $urandom;
      endcase
      run_model(2'($urandom), a, 3'($urandom), b, 3'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule